// File: doc/BRIEF.md
# Secure Doorbell Mailbox

This block is a small register unit that lets an application processor and a system control processor signal each other through 32-bit slot bitmaps. There is one channel for each direction. Each channel holds a status word, which the sender changes through a write-one-to-set register. The receiver acknowledges a message through a write-one-to-clear register. A slot bit stays set until the receiver clears it. While the bit is set, the sender treats the slot as busy.

Every access on the register bus carries a non-secure attribute, and the block polices it. A non-secure access to any register of a channel leaves that channel's slots untouched and sets the top status bit of that channel as a violation flag. A non-secure read returns zero. Each channel drives a level interrupt toward its receiver. The interrupt stays high for as long as the channel's status word is non-zero.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset, both status words read as zero and both interrupt outputs are low.
- R2: A secure write to a set register (0x308 for the processor-to-controller channel, 0x208 for the controller-to-processor channel) sets each status bit among 30:0 whose write-data bit is one. The other bits keep their values, and set bits persist across unrelated traffic.
- R3: A secure write to a clear register (0x310 and 0x210) clears each status bit, bit 31 included, whose write-data bit is one. The other bits are left unchanged.
- R4: A secure read of a status offset (0x300 and 0x200) returns that channel's current status word in the read cycle.
- R5: Bit 31 of a status word is ignored when it is written through a set register. Only a non-secure access sets it.
- R6: A non-secure read or write to any of a channel's three registers sets bit 31 of that channel only. It leaves slot bits 30:0 of both channels unchanged, and a non-secure read returns zero.
- R7: irq_to_ctrl is high exactly when the processor-to-controller status is non-zero. irq_to_cpu is high exactly when the controller-to-processor status is non-zero.
- R8: Reads of set and clear registers and of unmapped offsets return zero. Writes to unmapped offsets change no state.
- R9: The two channels are independent. A write to one channel's registers never changes the other channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data valid in the same cycle |
| bus_nonsec | input | 1 | High marks the access as non-secure |
| bus_rdata | output | 32 | Read data, zero when no read is in progress |
| irq_to_ctrl | output | 1 | Level interrupt for the processor-to-controller channel |
| irq_to_cpu | output | 1 | Level interrupt for the controller-to-processor channel |

## Verification
The following rules are checked on every cycle:
- Non-secure traffic never moves a slot bit.
- Non-secure reads and reads of set or clear offsets return zero.
- The violation flag rises only after a non-secure access.
- Slot bits hold steady while no write occurs.
- A clear write empties the bits it names.

Only the bench scenarios can show the following:
- The exact status value after a mix of set and clear masks.
- That bit 31 written through a set register is dropped.
- That the channels stay independent.
- That unmapped writes are harmless.
- That each interrupt follows its own channel as messages arrive and are acknowledged.

// File: rtl/doorbell_mbox.sv
module doorbell_mbox #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] TO_CTRL_BASE = 12'h300,
  parameter logic [ADDR_W-1:0] TO_CPU_BASE  = 12'h200,
  parameter logic [ADDR_W-1:0] SET_OFS      = 12'h008,
  parameter logic [ADDR_W-1:0] CLR_OFS      = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_nonsec,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_to_ctrl,
  output logic              irq_to_cpu
);
  localparam int NCH  = 2;
  localparam int FLAG = DATA_W - 1;

  logic [DATA_W-1:0] stat_ctrl, stat_cpu;

  for (genvar ch = 0; ch < NCH; ch++) begin : gen_ch
    localparam logic [ADDR_W-1:0] BASE = (ch == 0) ? TO_CTRL_BASE : TO_CPU_BASE;
    localparam logic [ADDR_W-1:0] A_SET = BASE + SET_OFS;
    localparam logic [ADDR_W-1:0] A_CLR = BASE + CLR_OFS;

    logic [DATA_W-1:0] st, set_v, clr_v, rpart;
    logic hit_st, hit_set, hit_clr, ns_hit, sec_wr;

    assign hit_st  = bus_addr == BASE;
    assign hit_set = bus_addr == A_SET;
    assign hit_clr = bus_addr == A_CLR;
    assign ns_hit  = bus_nonsec & (bus_wr | bus_rd) & (hit_st | hit_set | hit_clr);
    assign sec_wr  = bus_wr & ~bus_nonsec;

    assign set_v = ({DATA_W{sec_wr & hit_set}} & {1'b0, bus_wdata[FLAG-1:0]})
                 | {ns_hit, {FLAG{1'b0}}};
    assign clr_v = {DATA_W{sec_wr & hit_clr}} & bus_wdata;

    always_ff @(posedge clk) begin
      if (!rst_n) st <= '0;
      else        st <= (st & ~clr_v) | set_v;
    end

    assign rpart = (bus_rd & ~bus_nonsec & hit_st) ? st : '0;
  end

  assign stat_ctrl   = gen_ch[0].st;
  assign stat_cpu    = gen_ch[1].st;
  assign bus_rdata   = gen_ch[0].rpart | gen_ch[1].rpart;
  assign irq_to_ctrl = |stat_ctrl;
  assign irq_to_cpu  = |stat_cpu;
endmodule

module doorbell_mbox_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] TO_CTRL_BASE = 12'h300,
  parameter logic [ADDR_W-1:0] TO_CPU_BASE  = 12'h200,
  parameter logic [ADDR_W-1:0] SET_OFS      = 12'h008,
  parameter logic [ADDR_W-1:0] CLR_OFS      = 12'h010
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_nonsec,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_to_ctrl,
  input logic              irq_to_cpu,
  input logic [DATA_W-1:0] stat_ctrl,
  input logic [DATA_W-1:0] stat_cpu
);
  localparam int FLAG = DATA_W - 1;
  localparam logic [ADDR_W-1:0] C_SET = TO_CTRL_BASE + SET_OFS;
  localparam logic [ADDR_W-1:0] C_CLR = TO_CTRL_BASE + CLR_OFS;
  localparam logic [ADDR_W-1:0] P_SET = TO_CPU_BASE + SET_OFS;
  localparam logic [ADDR_W-1:0] P_CLR = TO_CPU_BASE + CLR_OFS;

  // R6
  ns_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nonsec && (bus_wr || bus_rd) |=>
      $stable(stat_ctrl[FLAG-1:0]) && $stable(stat_cpu[FLAG-1:0]));

  // R6
  ns_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_nonsec |-> bus_rdata == '0);

  // R5
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ctrl[FLAG]) || $rose(stat_cpu[FLAG]) |-> $past(bus_nonsec && (bus_wr || bus_rd)));

  // R3
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_nonsec && bus_addr == C_CLR |=> (stat_ctrl & $past(bus_wdata)) == '0);

  // R8
  setclr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == C_SET || bus_addr == C_CLR || bus_addr == P_SET || bus_addr == P_CLR)
      |-> bus_rdata == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(stat_ctrl[FLAG-1:0]) && $stable(stat_cpu[FLAG-1:0]));

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_to_ctrl) || $rose(irq_to_cpu) |-> $past(bus_wr || bus_rd));
endmodule

bind doorbell_mbox doorbell_mbox_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TO_CTRL_BASE(TO_CTRL_BASE),
  .TO_CPU_BASE(TO_CPU_BASE), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (.*);

// File: tb/test_doorbell_mbox.sv
module test_doorbell_mbox;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 0, bus_rd = 0, bus_nonsec = 0;
  logic [31:0] bus_rdata;
  logic        irq_to_ctrl, irq_to_cpu;

  doorbell_mbox i_doorbell_mbox (.*);

  always #5 clk = ~clk;

  typedef struct { logic [31:0] d; logic ic; logic ip; string tag; } exp_t;
  exp_t sb[$];
  logic [31:0] m_ctrl = '0, m_cpu = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic in_ch(logic [11:0] a, logic [11:0] b);
    return a == b || a == b + 12'h8 || a == b + 12'h10;
  endfunction

  function automatic logic [31:0] upd(logic [31:0] m, logic [11:0] b, logic [11:0] a,
                                      logic [31:0] d, logic w, logic r, logic ns);
    if (ns && (w || r) && in_ch(a, b)) return m | 32'h8000_0000;
    if (w && !ns && a == b + 12'h8)    return m | (d & 32'h7FFF_FFFF);
    if (w && !ns && a == b + 12'h10)   return m & ~d;
    return m;
  endfunction

  task automatic access(input logic [11:0] a, input logic [31:0] d,
                        input logic w, input logic r, input logic ns, input string tag);
    exp_t e;
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; bus_nonsec = ns;
    if (r) begin
      e.d = ns ? 32'h0 : (a == 12'h300) ? m_ctrl : (a == 12'h200) ? m_cpu : 32'h0;
      e.ic = m_ctrl != 0; e.ip = m_cpu != 0; e.tag = tag;
      sb.push_back(e);
    end
    m_ctrl = upd(m_ctrl, 12'h300, a, d, w, r, ns);
    m_cpu  = upd(m_cpu,  12'h200, a, d, w, r, ns);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; bus_nonsec = 0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      exp_t e;
      if (sb.size() == 0) chk(32'h1, 32'h0, "scoreboard underflow");
      else begin
        e = sb.pop_front();
        chk(bus_rdata, e.d, e.tag);
        chk({31'b0, irq_to_ctrl}, {31'b0, e.ic}, {e.tag, " R7 irq_to_ctrl"});
        chk({31'b0, irq_to_cpu},  {31'b0, e.ip}, {e.tag, " R7 irq_to_cpu"});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk({30'b0, irq_to_ctrl, irq_to_cpu}, 32'h0, "R1 irqs after reset");
    access(12'h300, 0, 0, 1, 0, "R1 ctrl status reset");
    access(12'h200, 0, 0, 1, 0, "R1 cpu status reset");
    access(12'h308, 32'h0000_00F1, 1, 0, 0, "");
    access(12'h300, 0, 0, 1, 0, "R2 R4 set slots");
    access(12'h200, 0, 0, 1, 0, "R9 other channel untouched");
    access(12'h308, 32'h8000_0100, 1, 0, 0, "");
    access(12'h300, 0, 0, 1, 0, "R5 bit31 via set ignored");
    access(12'h310, 32'h0000_0011, 1, 0, 0, "");
    access(12'h300, 0, 0, 1, 0, "R3 partial clear");
    access(12'h308, 0, 0, 1, 0, "R8 set reg reads zero");
    access(12'h310, 0, 0, 1, 0, "R8 clear reg reads zero");
    access(12'h304, 0, 0, 1, 0, "R8 unmapped read");
    access(12'h304, 32'hFFFF_FFFF, 1, 0, 0, "");
    access(12'h300, 0, 0, 1, 0, "R8 unmapped write ignored");
    access(12'h208, 32'h4000_0002, 1, 0, 0, "");
    access(12'h300, 0, 0, 1, 0, "R9 ctrl unaffected by cpu set");
    access(12'h200, 0, 0, 1, 0, "R2 cpu channel set");
    access(12'h208, 32'h0000_0001, 1, 0, 1, "");
    access(12'h200, 0, 0, 1, 0, "R6 ns write flags only");
    access(12'h300, 0, 0, 1, 1, "R6 ns read returns zero");
    access(12'h300, 0, 0, 1, 0, "R6 ns read flags ctrl");
    repeat (3) idle();
    access(12'h300, 0, 0, 1, 0, "R2 bits persist");
    access(12'h310, 32'hFFFF_FFFF, 1, 0, 0, "");
    access(12'h300, 0, 0, 1, 0, "R3 R7 full clear");
    access(12'h210, 32'h8000_0000, 1, 0, 0, "");
    access(12'h200, 0, 0, 1, 0, "R3 clear flag only");
    access(12'h210, 32'h4000_0002, 1, 0, 0, "");
    access(12'h200, 0, 0, 1, 0, "R3 R7 cpu emptied");
    access(12'h300, 0, 0, 1, 0, "R7 both idle");
    idle();
    @(negedge clk);
    chk({30'b0, irq_to_ctrl, irq_to_cpu}, 32'h0, "R7 irqs low at end");
    chk(sb.size(), 0, "scoreboard drained");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule